// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit unsigned operands and a carry-in. It returns the 16-bit sum and the carry-out. The datapath is split into four 4-bit slices. Each slice derives a generate term (both operand bits set) and a propagate term (either operand bit set) for every bit. From these it computes its own internal carries as flat sums of products. It also reports a slice-wide generate and a slice-wide propagate.

A second-level lookahead unit takes the four slice-wide terms and the carry-in. It produces the carry into every slice and the final carry-out directly, so no carry travels from one slice to the next. Sum bits are the exclusive-OR of the two operand bits and the incoming carry.

For test and timing closure the adder core sits inside a wrapper. The wrapper registers the sum and carry-out, so results appear one clock after the operands.

Top module: `cla16_reg`

## Requirements
- R1: One clock after operands A, B and carry-in C are presented, `out_sum` equals bits 15..0 of A + B + C.
- R2: One clock after the operands are presented, `out_cout` equals bit 16 of A + B + C.
- R3: The carry delivered into slice k (bit position 4k, k = 1..3) equals the carry out of the low 4k bits of A + B + C. It is therefore visible in `out_sum` at bit 4k, for example 0x0FFF + 0x0001 + 0 gives 0x1000.
- R4: Whenever a slice generates on its own (its slice-wide generate is 1), the carry out of that slice is 1, whatever the carry into it.
- R5: When a slice propagates without generating (every bit has at least one operand bit set, but the slice does not generate), its carry-out equals its carry-in. This holds even when the carry-in comes from the external carry input through all lower slices.
- R6: Carry-in 1 adds exactly one to the result. With both operands zero, it gives sum 0x0001 and carry-out 0.
- R7: All-ones operands give sum 0xFFFE and carry-out 1 with carry-in 0, and sum 0xFFFF and carry-out 1 with carry-in 1.
- R8: While `rst_n` is low, `out_sum` is 0 and `out_cout` is 0 from the next rising clock edge on. The reset is asynchronous and active low.
- R9: The outputs keep their previous value until the rising edge after an operand change. After that edge they show the new result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_x | input | 16 | First operand |
| in_y | input | 16 | Second operand |
| in_cin | input | 1 | Carry into bit 0 |
| out_sum | output | 16 | Registered sum bits |
| out_cout | output | 1 | Registered carry out of bit 15 |

## Verification
The assertions assume that the operands and the carry-in are settled at every rising clock edge. The combinational slice carries are sampled at that edge and compared with carries worked out from the operands. The bench therefore changes inputs only on falling edges, half a period away from the sampling edge. The registered result checks apply only once a full clock has passed with reset released. For this reason the bench holds the operands at defined values throughout reset and drives new patterns only after release.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int unsigned LA_MAX = 32;

    typedef struct packed {
        logic [LA_MAX-1:0] gen;
        logic [LA_MAX-1:0] prop;
    } gp_vec_t;

    // Flat sum-of-products carry into position idx+1:
    // OR over k<=idx of (gen[k] & prop[k+1..idx]) OR (prop[0..idx] & cin)
    function automatic logic sop_carry(input gp_vec_t v, input logic cin, input int idx);
        logic acc;
        logic prod;
        acc = 1'b0;
        for (int k = 0; k <= idx; k++) begin
            prod = v.gen[k];
            for (int m = k + 1; m <= idx; m++) begin
                prod = prod & v.prop[m];
            end
            acc = acc | prod;
        end
        prod = cin;
        for (int m = 0; m <= idx; m++) begin
            prod = prod & v.prop[m];
        end
        return acc | prod;
    endfunction

endpackage

// File: rtl/cla_slice.sv
module cla_slice
    import cla_pkg::*;
#(
    parameter int unsigned SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] op_a,
    input  logic [SLICE_W-1:0] op_b,
    input  logic               c_in,
    output logic [SLICE_W-1:0] sum,
    output logic               blk_gen,
    output logic               blk_prop
);

    logic [SLICE_W-1:0] bit_gen;
    logic [SLICE_W-1:0] bit_prop;
    logic [SLICE_W:0]   carry;
    gp_vec_t            gp_v;

    assign bit_gen  = op_a & op_b;
    assign bit_prop = op_a | op_b;

    always_comb begin
        gp_v      = '0;
        gp_v.gen  = LA_MAX'(bit_gen);
        gp_v.prop = LA_MAX'(bit_prop);
        carry[0]  = c_in;
        for (int j = 0; j < int'(SLICE_W); j++) begin
            carry[j+1] = sop_carry(gp_v, c_in, j);
        end
        // slice-wide terms: generate ignores the carry-in, propagate is the AND chain
        blk_gen  = sop_carry(gp_v, 1'b0, int'(SLICE_W) - 1);
        blk_prop = &bit_prop;
    end

    assign sum = op_a ^ op_b ^ carry[SLICE_W-1:0];

endmodule

// File: rtl/cla_level2.sv
module cla_level2
    import cla_pkg::*;
#(
    parameter int unsigned NUM_SLICE = 4
) (
    input  logic [NUM_SLICE-1:0] blk_gen,
    input  logic [NUM_SLICE-1:0] blk_prop,
    input  logic                 c_in,
    output logic [NUM_SLICE:0]   slice_c
);

    gp_vec_t gp_v;

    always_comb begin
        gp_v       = '0;
        gp_v.gen   = LA_MAX'(blk_gen);
        gp_v.prop  = LA_MAX'(blk_prop);
        slice_c[0] = c_in;
        for (int j = 0; j < int'(NUM_SLICE); j++) begin
            slice_c[j+1] = sop_carry(gp_v, c_in, j);
        end
    end

endmodule

// File: rtl/cla_core.sv
module cla_core #(
    parameter int unsigned SLICE_W   = 4,
    parameter int unsigned NUM_SLICE = 4,
    localparam int unsigned WIDTH    = SLICE_W * NUM_SLICE
) (
    input  logic [WIDTH-1:0]     op_a,
    input  logic [WIDTH-1:0]     op_b,
    input  logic                 c_in,
    output logic [WIDTH-1:0]     sum,
    output logic                 c_out,
    output logic [NUM_SLICE-1:0] blk_gen,
    output logic [NUM_SLICE-1:0] blk_prop,
    output logic [NUM_SLICE:0]   slice_c
);

    for (genvar s = 0; s < NUM_SLICE; s++) begin : g_slice
        cla_slice #(.SLICE_W(SLICE_W)) u_slice (
            .op_a     (op_a[s*SLICE_W +: SLICE_W]),
            .op_b     (op_b[s*SLICE_W +: SLICE_W]),
            .c_in     (slice_c[s]),
            .sum      (sum[s*SLICE_W +: SLICE_W]),
            .blk_gen  (blk_gen[s]),
            .blk_prop (blk_prop[s])
        );
    end

    cla_level2 #(.NUM_SLICE(NUM_SLICE)) u_level2 (
        .blk_gen  (blk_gen),
        .blk_prop (blk_prop),
        .c_in     (c_in),
        .slice_c  (slice_c)
    );

    assign c_out = slice_c[NUM_SLICE];

endmodule

// File: rtl/cla16_reg.sv
module cla16_reg #(
    parameter int unsigned SLICE_W   = 4,
    parameter int unsigned NUM_SLICE = 4,
    localparam int unsigned WIDTH    = SLICE_W * NUM_SLICE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_x,
    input  logic [WIDTH-1:0] in_y,
    input  logic             in_cin,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_cout
);

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
    } res_t;

    logic [WIDTH-1:0]     core_sum;
    logic                 core_cout;
    logic [NUM_SLICE-1:0] blk_gen;
    logic [NUM_SLICE-1:0] blk_prop;
    logic [NUM_SLICE:0]   slice_c;
    res_t                 res_d;
    res_t                 res_q;

    cla_core #(.SLICE_W(SLICE_W), .NUM_SLICE(NUM_SLICE)) u_core (
        .op_a     (in_x),
        .op_b     (in_y),
        .c_in     (in_cin),
        .sum      (core_sum),
        .c_out    (core_cout),
        .blk_gen  (blk_gen),
        .blk_prop (blk_prop),
        .slice_c  (slice_c)
    );

    always_comb begin
        res_d      = res_q;
        res_d.sum  = core_sum;
        res_d.cout = core_cout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_sum  = res_q.sum;
    assign out_cout = res_q.cout;

endmodule

// File: rtl/cla16_chk.sv
module cla16_chk #(
    parameter int unsigned SLICE_W   = 4,
    parameter int unsigned NUM_SLICE = 4,
    localparam int unsigned WIDTH    = SLICE_W * NUM_SLICE
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [WIDTH-1:0]     in_x,
    input logic [WIDTH-1:0]     in_y,
    input logic                 in_cin,
    input logic [WIDTH-1:0]     out_sum,
    input logic                 out_cout,
    input logic [NUM_SLICE-1:0] blk_gen,
    input logic [NUM_SLICE-1:0] blk_prop,
    input logic [NUM_SLICE:0]   slice_c
);

    logic [WIDTH:0]     ref_q;
    logic               live_q;
    logic [NUM_SLICE:0] ref_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q  <= '0;
            live_q <= 1'b0;
        end else begin
            ref_q  <= {1'b0, in_x} + {1'b0, in_y} + {{WIDTH{1'b0}}, in_cin};
            live_q <= 1'b1;
        end
    end

    always_comb begin
        logic [WIDTH:0] part;
        logic [WIDTH:0] msk;
        for (int k = 0; k <= int'(NUM_SLICE); k++) begin
            msk      = ({{WIDTH{1'b0}}, 1'b1} << (k * int'(SLICE_W))) - 1'b1;
            part     = ({1'b0, in_x} & msk) + ({1'b0, in_y} & msk) + {{WIDTH{1'b0}}, in_cin};
            ref_c[k] = part[k * int'(SLICE_W)] | ((k == 0) ? in_cin : 1'b0);
        end
    end

    p_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (out_sum == ref_q[WIDTH-1:0]));

    p_cout_r2: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (out_cout == ref_q[WIDTH]));

    for (genvar k = 1; k <= NUM_SLICE; k++) begin : g_chk
        p_slice_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
            slice_c[k] == ref_c[k]);

        p_gen_forces_r4: assert property (@(posedge clk) disable iff (!rst_n)
            blk_gen[k-1] |-> slice_c[k]);

        p_prop_passes_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (blk_prop[k-1] && !blk_gen[k-1]) |-> (slice_c[k] == slice_c[k-1]));
    end

endmodule

bind cla16_reg cla16_chk #(.SLICE_W(SLICE_W), .NUM_SLICE(NUM_SLICE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_x     (in_x),
    .in_y     (in_y),
    .in_cin   (in_cin),
    .out_sum  (out_sum),
    .out_cout (out_cout),
    .blk_gen  (blk_gen),
    .blk_prop (blk_prop),
    .slice_c  (slice_c)
);

// File: tb/tb_cla16_reg.sv
module tb_cla16_reg;

    logic        clk;
    logic        rst_n;
    logic [15:0] in_x;
    logic [15:0] in_y;
    logic        in_cin;
    logic [15:0] out_sum;
    logic        out_cout;
    int          n_chk;
    int          n_bad;
    logic        wd_hit;

    cla16_reg dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_x     (in_x),
        .in_y     (in_y),
        .in_cin   (in_cin),
        .out_sum  (out_sum),
        .out_cout (out_cout)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // present operands on a falling edge, sample on the next falling edge
    task automatic apply(input string req, input logic [15:0] a, input logic [15:0] b, input logic c);
        logic [16:0] exp;
        @(negedge clk);
        in_x = a; in_y = b; in_cin = c;
        exp = {1'b0, a} + {1'b0, b} + {16'd0, c};
        @(negedge clk);
        check(req, {out_cout, out_sum}, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        in_x = 16'hFFFF; in_y = 16'hFFFF; in_cin = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", {out_cout, out_sum}, 17'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic;
        apply("R1", 16'h1234, 16'h4321, 1'b0);
        apply("R1", 16'h7FFF, 16'h0001, 1'b0);
        apply("R2", 16'h8000, 16'h8000, 1'b0);
        apply("R2", 16'hC000, 16'h4000, 1'b0);
    endtask

    task automatic t_slice_edges;
        apply("R3", 16'h000F, 16'h0001, 1'b0);
        apply("R3", 16'h00FF, 16'h0001, 1'b0);
        apply("R3", 16'h0FFF, 16'h0001, 1'b0);
        apply("R3", 16'h0FFF, 16'h0000, 1'b1);
    endtask

    task automatic t_generate;
        // each slice generates from bit 3 alone
        apply("R4", 16'h8888, 16'h8888, 1'b0);
        apply("R4", 16'h0800, 16'h0800, 1'b0);
    endtask

    task automatic t_propagate;
        // slices propagate without generating: 0xF0F0 | 0x0F0F, carry-in rides all the way
        apply("R5", 16'hF0F0, 16'h0F0F, 1'b1);
        apply("R5", 16'hF0F0, 16'h0F0F, 1'b0);
        apply("R5", 16'hA5A5, 16'h5A5A, 1'b1);
    endtask

    task automatic t_cin;
        apply("R6", 16'h0000, 16'h0000, 1'b1);
        apply("R6", 16'h1111, 16'h2222, 1'b1);
    endtask

    task automatic t_all_ones;
        apply("R7", 16'hFFFF, 16'hFFFF, 1'b0);
        apply("R7", 16'hFFFF, 16'hFFFF, 1'b1);
        apply("R7", 16'hFFFF, 16'h0000, 1'b1);
    endtask

    task automatic t_latency;
        logic [16:0] old_v;
        apply("R9", 16'h0003, 16'h0004, 1'b0);
        old_v = 17'd7;
        @(negedge clk);
        in_x = 16'h0100; in_y = 16'h0200; in_cin = 1'b0;
        #1;
        check("R9", {out_cout, out_sum}, old_v);
        @(negedge clk);
        check("R9", {out_cout, out_sum}, 17'h00300);
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            apply("R1", 16'($urandom), 16'($urandom), 1'($urandom));
        end
    endtask

    initial begin
        n_chk = 0; n_bad = 0; wd_hit = 1'b0;
        t_reset();
        t_basic();
        t_slice_edges();
        t_generate();
        t_propagate();
        t_cin();
        t_all_ones();
        t_latency();
        t_random();
        if (!wd_hit) begin
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        wd_hit = 1'b1;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule